// File: doc/BRIEF.md
# Synchronous Power-Down Output Sequencer

This block stops a clock generator's output groups in a fixed order when an asynchronous active-low power-down request arrives. The request must first be confirmed on consecutive rising edges of the CPU complement clock. Each single-ended output group then stops on its own next falling edge, so no shortened pulse reaches a pin. The CPU differential pair is parked at a fixed level or in high impedance, depending on two mode bits. Once every group is at rest, the block raises a done flag so that the rest of the generator may shut down.

The block runs on one sampling clock that is faster than the output clocks it watches. Each output clock reaches it as a level indicator that is synchronous to that sampling clock. For every group it produces a gate enable and a two-bit output-state code:

- 00: running
- 01: drive low
- 10: drive high
- 11: high impedance

Release of the request is asynchronous. Stopped groups restart when their source clock is low. A tick-based counter flags any restart that takes too long.

Top module: `pd_out_sequencer`

## Requirements
- R1: Power-down takes effect only after `pd_n`, once through a two-stage synchronizer, is seen low at QUAL_EDGES (default 2) consecutive rising edges of `cpuc_lvl`. A synchronized high sample restarts the count. Qualification drops `cpu_gate_en` at the edge of the last counted rise.
- R2: After qualification, a group's `gate_en` bit goes low only at the clock edge where that group's level is seen going from 1 to 0. Its `dom_code` field (bits 2i+1:2i) then reads 01 (drive low); while running it reads 00.
- R3: Group 0 (the PCIF group) stops first. Group 1 (the 66 MHz buffer group) stops only on a falling edge seen after group 0 has stopped. Groups 2 and above (PCI, USB/DOT, REF) stop only on a falling edge seen after group 1 has stopped.
- R4: While power-down is qualified and both `tri_a` and `tri_b` are 0, `cpu_t_code` is 10 (drive high) and `cpu_c_code` is 01 (drive low). Outside power-down both codes are 00.
- R5: While power-down is qualified and either `tri_a` or `tri_b` is 1, both `cpu_t_code` and `cpu_c_code` are 11 (high impedance).
- R6: `shutdown_done` rises one cycle after the last group's gate turns off while power-down stays qualified. It is never high while any `gate_en` bit is 1.
- R7: Once the synchronized `pd_n` is seen high, `cpu_gate_en` returns to 1 and `shutdown_done` clears on the next cycle. Each stopped group restarts at the first edge where its level is seen low.
- R8: If any group is still stopped after WAKE_TICKS pulses of `tick` following release, `wake_timeout` sets. It stays set until the next qualified power-down clears it.
- R9: Reset puts all gates on, all codes at 00, and clears `shutdown_done` and `wake_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpuc_lvl | input | 1 | Level of the CPU complement clock |
| dom_lvl | input | NDOM | Levels of the single-ended groups: 0 PCIF, 1 66 MHz buffer, then PCI, USB/DOT, REF |
| tri_a | input | 1 | First high-impedance mode bit for the CPU pair |
| tri_b | input | 1 | Second high-impedance mode bit for the CPU pair |
| tick | input | 1 | Slow reference tick for the restart bound |
| gate_en | output | NDOM | Per-group gate enable |
| dom_code | output | 2*NDOM | Per-group output-state code |
| cpu_gate_en | output | 1 | CPU pair gate enable |
| cpu_t_code | output | 2 | CPU true output-state code |
| cpu_c_code | output | 2 | CPU complement output-state code |
| shutdown_done | output | 1 | All groups at rest |
| wake_timeout | output | 1 | Restart exceeded its tick bound |

## Verification
- **Synchronizer delay:** a `pd_n` change is first visible to the sequencer two edges after it is driven.
- **CPU pair:** the CPU gate and codes change at the edge of the second counted complement rise. On release they return three edges after `pd_n` rises.
- **Group gates:** a gate changes at the same edge that sees its falling (or low) level.
- **Done and timeout:** `shutdown_done` follows the last stop by one edge. `wake_timeout` sets at the edge of the WAKE_TICKS-th tick.

The bench drives inputs and samples outputs 5 ns after each rising edge, so every expected value is tied to a specific edge count.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [1:0] {
        OUT_RUN  = 2'b00,
        OUT_LOW  = 2'b01,
        OUT_HIGH = 2'b10,
        OUT_HIZ  = 2'b11
    } out_code_e;

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/pdseq_edge.sv
module pdseq_edge #(
    parameter int   W      = 1,
    parameter logic RISING = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (RISING) begin : g_rise
            assign hit[i] = lvl[i] & ~prev_q[i];
        end else begin : g_fall
            assign hit[i] = ~lvl[i] & prev_q[i];
        end
    end
endmodule

// File: rtl/pdseq_wake_timer.sv
module pdseq_wake_timer #(
    parameter int WAKE_TICKS = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic tick,
    input  logic clr,
    output logic expired
);
    localparam int TW = $clog2(WAKE_TICKS + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          flag_d, flag_q;

    always_comb begin
        cnt_d  = cnt_q;
        flag_d = flag_q;
        if (!busy) begin
            cnt_d = '0;
        end else if (tick && cnt_q != TW'(WAKE_TICKS)) begin
            cnt_d = cnt_q + TW'(1);
        end
        if (busy && tick && cnt_q == TW'(WAKE_TICKS - 1)) flag_d = 1'b1;
        if (clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    assign expired = flag_q;
endmodule

// File: rtl/pd_out_sequencer.sv
module pd_out_sequencer import pdseq_pkg::*; #(
    parameter int NDOM        = 5,
    parameter int QUAL_EDGES  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int WAKE_TICKS  = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_n,
    input  logic              cpuc_lvl,
    input  logic [NDOM-1:0]   dom_lvl,
    input  logic              tri_a,
    input  logic              tri_b,
    input  logic              tick,
    output logic [NDOM-1:0]   gate_en,
    output logic [2*NDOM-1:0] dom_code,
    output logic              cpu_gate_en,
    output logic [1:0]        cpu_t_code,
    output logic [1:0]        cpu_c_code,
    output logic              shutdown_done,
    output logic              wake_timeout
);
    localparam int QW = $clog2(QUAL_EDGES + 1);

    typedef struct packed {
        logic [QW-1:0]   qual_cnt;
        logic [NDOM-1:0] stopped;
        logic            done;
    } seq_t;

    seq_t            seq_d, seq_q;
    logic            pd_sync;
    logic            pd_low_s;
    logic            cpuc_rise;
    logic [NDOM-1:0] dom_fall;
    logic [NDOM-1:0] armed;
    logic            qual_now;
    logic            wake_busy;

    pdseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pd_n), .q(pd_sync)
    );
    assign pd_low_s = ~pd_sync;

    pdseq_edge #(.W(1), .RISING(1'b1)) u_cpuc_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cpuc_lvl), .hit(cpuc_rise)
    );

    pdseq_edge #(.W(NDOM), .RISING(1'b0)) u_dom_edge (
        .clk(clk), .rst_n(rst_n), .lvl(dom_lvl), .hit(dom_fall)
    );

    assign qual_now = (seq_q.qual_cnt == QW'(QUAL_EDGES));

    for (genvar i = 0; i < NDOM; i++) begin : g_dom
        if (i == 0) begin : g_first
            assign armed[i] = qual_now;
        end else if (i == 1) begin : g_second
            assign armed[i] = seq_q.stopped[0];
        end else begin : g_rest
            assign armed[i] = seq_q.stopped[1];
        end
        assign dom_code[2*i +: 2] = seq_q.stopped[i] ? OUT_LOW : OUT_RUN;
    end

    always_comb begin
        seq_d = seq_q;
        if (!pd_low_s) begin
            seq_d.qual_cnt = '0;
        end else if (cpuc_rise && !qual_now) begin
            seq_d.qual_cnt = seq_q.qual_cnt + QW'(1);
        end
        for (int i = 0; i < NDOM; i++) begin
            if (qual_now) seq_d.stopped[i] = seq_q.stopped[i] | (armed[i] & dom_fall[i]);
            else          seq_d.stopped[i] = seq_q.stopped[i] & dom_lvl[i];
        end
        seq_d.done = qual_now & (&seq_q.stopped);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign wake_busy = ~qual_now & (|seq_q.stopped);

    pdseq_wake_timer #(.WAKE_TICKS(WAKE_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .busy(wake_busy), .tick(tick),
        .clr(qual_now), .expired(wake_timeout)
    );

    assign gate_en       = ~seq_q.stopped;
    assign cpu_gate_en   = ~qual_now;
    assign cpu_t_code    = qual_now ? ((tri_a | tri_b) ? OUT_HIZ : OUT_HIGH) : OUT_RUN;
    assign cpu_c_code    = qual_now ? ((tri_a | tri_b) ? OUT_HIZ : OUT_LOW)  : OUT_RUN;
    assign shutdown_done = seq_q.done;
endmodule

// File: rtl/pd_out_sequencer_chk.sv
module pd_out_sequencer_chk #(
    parameter int NDOM = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pd_low_s,
    input logic [NDOM-1:0] gate_en,
    input logic [NDOM-1:0] dom_lvl,
    input logic            cpu_gate_en,
    input logic [1:0]      cpu_t_code,
    input logic [1:0]      cpu_c_code,
    input logic            tri_a,
    input logic            tri_b,
    input logic            shutdown_done,
    input logic            wake_timeout
);
    AST_QUAL_FROM_LOW_PD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_gate_en) |-> $past(pd_low_s)); // R1

    for (genvar i = 0; i < NDOM; i++) begin : g_chk
        AST_STOP_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_en[i]) |-> (!$past(dom_lvl[i]) && $past(dom_lvl[i], 2))); // R2
        if (i == 1) begin : g_o1
            AST_ORDER_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(gate_en[1]) |-> !gate_en[0]); // R3
        end else if (i > 1) begin : g_on
            AST_ORDER_REST: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(gate_en[i]) |-> !gate_en[1]); // R3
        end
    end

    AST_CPU_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_gate_en && !tri_a && !tri_b) |-> (cpu_t_code == 2'b10 && cpu_c_code == 2'b01)); // R4
    AST_CPU_HIZ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_t_code == 2'b11) |-> (cpu_c_code == 2'b11 && !cpu_gate_en && (tri_a || tri_b))); // R5
    AST_DONE_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_done |-> (gate_en == '0)); // R6
    AST_RELEASE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_low_s |=> cpu_gate_en); // R7
    AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_timeout) |-> !(&$past(gate_en))); // R8
endmodule

bind pd_out_sequencer pd_out_sequencer_chk #(.NDOM(NDOM)) u_chk (
    .clk(clk), .rst_n(rst_n), .pd_low_s(pd_low_s), .gate_en(gate_en),
    .dom_lvl(dom_lvl), .cpu_gate_en(cpu_gate_en), .cpu_t_code(cpu_t_code),
    .cpu_c_code(cpu_c_code), .tri_a(tri_a), .tri_b(tri_b),
    .shutdown_done(shutdown_done), .wake_timeout(wake_timeout)
);

// File: tb/sim_pd_out_sequencer.sv
`timescale 1ns/1ps
module sim_pd_out_sequencer;
    localparam int NDOM = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pd_n = 1'b1;
    logic              cpuc_lvl = 1'b0;
    logic [NDOM-1:0]   dom_lvl = '0;
    logic              tri_a = 1'b0;
    logic              tri_b = 1'b0;
    logic              tick = 1'b0;
    logic [NDOM-1:0]   gate_en;
    logic [2*NDOM-1:0] dom_code;
    logic              cpu_gate_en;
    logic [1:0]        cpu_t_code;
    logic [1:0]        cpu_c_code;
    logic              shutdown_done;
    logic              wake_timeout;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  reported = 1'b0;

    always #10 clk = ~clk;

    pd_out_sequencer #(.NDOM(NDOM), .QUAL_EDGES(2), .SYNC_STAGES(2), .WAKE_TICKS(3)) u0 (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpuc_lvl(cpuc_lvl), .dom_lvl(dom_lvl),
        .tri_a(tri_a), .tri_b(tri_b), .tick(tick), .gate_en(gate_en), .dom_code(dom_code),
        .cpu_gate_en(cpu_gate_en), .cpu_t_code(cpu_t_code), .cpu_c_code(cpu_c_code),
        .shutdown_done(shutdown_done), .wake_timeout(wake_timeout)
    );

    // {pd_n, cpuc, dom[4:0], exp gate[4:0], exp cpu_gate, exp done}
    localparam logic [13:0] VEC [16] = '{
        14'b1_0_11111_11111_1_0,
        14'b0_1_11111_11111_1_0,
        14'b0_0_11111_11111_1_0,
        14'b0_1_11111_11111_1_0,
        14'b0_0_00000_11111_1_0,
        14'b0_1_11111_11111_0_0,
        14'b0_0_01100_11110_0_0,
        14'b0_1_11111_11110_0_0,
        14'b0_0_11101_11100_0_0,
        14'b0_1_00001_00000_0_0,
        14'b0_0_00000_00000_0_1,
        14'b1_0_00000_00000_0_1,
        14'b1_0_11111_00000_0_1,
        14'b1_0_11111_00000_1_1,
        14'b1_0_11010_00101_1_0,
        14'b1_0_00000_11111_1_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic c, input logic [NDOM-1:0] d);
        pd_n = p;
        cpuc_lvl = c;
        dom_lvl = d;
        @(posedge clk);
        #5;
    endtask

    function automatic logic [2*NDOM-1:0] codes_of(input logic [NDOM-1:0] g);
        logic [2*NDOM-1:0] r;
        for (int i = 0; i < NDOM; i++) r[2*i +: 2] = g[i] ? 2'b00 : 2'b01;
        return r;
    endfunction

    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        @(posedge clk);
        #5;
        // R9 reset state
        chk("R9 gates", gate_en, 5'b11111);
        chk("R9 codes", {dom_code, cpu_t_code, cpu_c_code}, '0);
        chk("R9 cpu gate", cpu_gate_en, 1'b1);
        chk("R9 done/timeout", {shutdown_done, wake_timeout}, 2'b00);

        // table: qualification, ordered stops, done, release
        for (int k = 0; k < 16; k++) begin
            logic [13:0] v;
            v = VEC[k];
            step(v[13], v[12], v[11:7]);
            chk($sformatf("R2 R3 R7 vec%0d gates", k), gate_en, v[6:2]);
            chk($sformatf("R2 vec%0d codes", k), dom_code, codes_of(v[6:2]));
            chk($sformatf("R1 R7 vec%0d cpu gate", k), cpu_gate_en, v[1]);
            chk($sformatf("R4 vec%0d cpu codes", k), {cpu_t_code, cpu_c_code},
                v[1] ? 4'b0000 : 4'b1001);
            chk($sformatf("R6 vec%0d done", k), shutdown_done, v[0]);
        end

        // R1: a high synchronized sample restarts qualification
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        step(0, 0, 5'b11111);
        step(1, 1, 5'b11111);
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        chk("R1 one rise after restart", cpu_gate_en, 1'b1);
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        chk("R1 second rise qualifies", cpu_gate_en, 1'b0);

        // R5 / R4: tri-state mode bits
        tri_a = 1'b1;
        step(0, 0, 5'b11111);
        chk("R5 tri_a pair", {cpu_t_code, cpu_c_code}, 4'b1111);
        tri_a = 1'b0;
        tri_b = 1'b1;
        step(0, 1, 5'b11111);
        chk("R5 tri_b pair", {cpu_t_code, cpu_c_code}, 4'b1111);
        tri_b = 1'b0;
        step(0, 0, 5'b11111);
        chk("R4 parked pair", {cpu_t_code, cpu_c_code}, 4'b1001);
        chk("R2 no fall no stop", gate_en, 5'b11111);

        // stop all, then release while groups stay high -> R8
        step(0, 1, 5'b11110);
        step(0, 0, 5'b11100);
        step(0, 1, 5'b00000);
        step(0, 0, 5'b00000);
        chk("R6 done after all stop", shutdown_done, 1'b1);
        step(1, 0, 5'b11111);
        step(1, 0, 5'b11111);
        step(1, 0, 5'b11111);
        chk("R7 cpu back", cpu_gate_en, 1'b1);
        tick = 1'b1;
        step(1, 0, 5'b11111);
        step(1, 0, 5'b11111);
        chk("R8 not yet", wake_timeout, 1'b0);
        step(1, 0, 5'b11111);
        chk("R8 timeout set", wake_timeout, 1'b1);
        tick = 1'b0;
        step(1, 0, 5'b00000);
        chk("R7 groups resume when low", gate_en, 5'b11111);
        chk("R8 timeout held", wake_timeout, 1'b1);
        step(0, 1, 5'b11111);
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        step(0, 0, 5'b11111);
        step(0, 1, 5'b11111);
        chk("R1 requalified", cpu_gate_en, 1'b0);
        step(0, 0, 5'b11111);
        chk("R8 cleared by power-down", wake_timeout, 1'b0);

        // R9: reset while powered down
        rst_n = 1'b0;
        @(posedge clk);
        #5;
        chk("R9 reset mid power-down", {gate_en, cpu_gate_en, shutdown_done}, 7'b1111110);
        finish_run();
    end
endmodule